// File: doc/BRIEF.md
# Wishbone I2C Register Front-End

This block is the register file a processor uses to drive an I2C master engine. It is a Wishbone slave with a 16-bit data bus and two byte selects. Software reaches the engine's controls through a set of memory-mapped registers: a status word, a command port, a data port, a prescale setting, and an interrupt group (mask, raw flags, masked flags, clear). A separate register gates the engine clock.

Several registers act when software touches them. A write to the command port hands one command word to the engine's command FIFO. A write to the data port hands one byte to the write FIFO. A read of the data port takes one byte from the read FIFO. All three FIFO paths use valid/ready handshakes. A push that meets a full FIFO is dropped and raises a sticky overflow flag. A missed acknowledge reported by the engine is also kept as a sticky flag until software clears it. Nine interrupt sources are edge-detected into raw flags. The masked flags are ORed into one interrupt line.

Top module: `wb_i2c_regs`

## Requirements
- R1: A bus access with cyc and stb high is acknowledged exactly one clock later, for one cycle only. Read data is valid on wbDatO while ack is high.
- R2: Registers decode at byte offsets: status 0x0000, command 0x0004, data 0x0008, prescale 0x000C, mask 0xFF00, masked flags 0xFF04, raw flags 0xFF08, clear 0xFF0C, clock enable 0xFF10. All of them reset to zero. A read of any other offset returns 0.
- R3: Status reads as follows: bit0 engine busy, bit1 bus held by this master, bit2 bus active, bit3 missed ACK, bit8 command FIFO empty, bit9 command FIFO full (cmdReady low), bit10 command overflow, bit11 write FIFO empty, bit12 write FIFO full (wrReady low), bit13 write overflow, bit14 read FIFO empty (rdValid low), bit15 read FIFO full. All other bits read 0.
- R4: Each write to the command offset raises cmdValid for one cycle, with cmdWord equal to write data bits 12:0. If cmdReady is low, the word is dropped and the command overflow flag sets.
- R5: Each write to the data offset raises wrValid for one cycle, with wrByte equal to bits 7:0 and wrLast equal to bit 9. If wrReady is low, the byte is dropped and the write overflow flag sets.
- R6: A read of the data offset while rdValid is high pops one byte (rdReady for one cycle). It returns the byte in bits 7:0 with bit 8 set. While rdValid is low, the read returns 0 and does not pop.
- R7: Missed ACK, command overflow and write overflow stay set until software writes 1 to status bit 3, 10 or 13 respectively. Writing 0 to those bits leaves them unchanged. A new set event in the same cycle as a clear wins over the clear.
- R8: Raw flag bits are: 0 missed ACK, 1 command empty, 2 command full, 3 command overflow, 4 write empty, 5 write full, 6 write overflow, 7 read empty, 8 read full. A raw flag sets on a rising edge of its source and stays set while the source stays high. Writing 1 to the matching clear bit clears it. Writes to the raw and masked registers have no effect.
- R9: The masked flags equal the raw flags ANDed with the mask. irq is the OR of the masked flags.
- R10: The prescale and clock-enable registers drive the prescale and clkEn outputs. A write updates only the byte lanes selected by wbSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wbAdr | input | 16 | Byte address |
| wbDatI | input | 16 | Write data |
| wbDatO | output | 16 | Read data |
| wbSel | input | 2 | Byte lane selects |
| wbWe | input | 1 | Write enable |
| wbStb | input | 1 | Strobe |
| wbCyc | input | 1 | Bus cycle |
| wbAck | output | 1 | Acknowledge |
| cmdWord | output | 13 | Command word toward engine |
| cmdValid | output | 1 | Command push valid |
| cmdReady | input | 1 | Command FIFO can accept |
| wrByte | output | 8 | Write byte toward engine |
| wrLast | output | 1 | Last byte of block write |
| wrValid | output | 1 | Write byte push valid |
| wrReady | input | 1 | Write FIFO can accept |
| rdData | input | 8 | Head of read FIFO |
| rdValid | input | 1 | Read FIFO holds a byte |
| rdReady | output | 1 | Pop read FIFO |
| engBusy | input | 1 | Engine performing an operation |
| engBusCtl | input | 1 | Engine holds the bus |
| engBusAct | input | 1 | Bus is active |
| engMissAck | input | 1 | Pulse: slave ACK not seen |
| cmdEmpty | input | 1 | Command FIFO empty |
| wrEmpty | input | 1 | Write FIFO empty |
| rdFull | input | 1 | Read FIFO full |
| prescale | output | 16 | Quarter-bit tick count for the engine |
| clkEn | output | 1 | Engine clock enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench reads state back only through the bus or the engine-side outputs. Each fault has its own signature at the ports:
- A wrong sticky or raw flag appears in the next status or raw-flag read. It also reaches irq one cycle after the source edge once the flag is masked in.
- A decode fault sends a push or pop to the wrong FIFO. The bench sees the unexpected push in the accept cycle itself.
- A drop that fails to register shows as a missing overflow bit in the very next status read.

// File: rtl/wbi2c_pkg.sv
package wbi2c_pkg;

  localparam int IRQ_N  = 9;
  localparam int BUS_W  = 16;
  localparam int CMD_W  = 13;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_STAT, SEL_CMD, SEL_DATA, SEL_PRE,
    SEL_IM, SEL_MIS, SEL_RIS, SEL_IC, SEL_GCLK
  } regSel_e;

  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    regSel_e    sel;
    logic [1:0] byteEn;
  } busStrb_t;

  function automatic regSel_e decodeAddr(input logic [15:0] adr);
    regSel_e s;
    case ({adr[15:2], 2'b00})
      16'h0000: s = SEL_STAT;
      16'h0004: s = SEL_CMD;
      16'h0008: s = SEL_DATA;
      16'h000C: s = SEL_PRE;
      16'hFF00: s = SEL_IM;
      16'hFF04: s = SEL_MIS;
      16'hFF08: s = SEL_RIS;
      16'hFF0C: s = SEL_IC;
      16'hFF10: s = SEL_GCLK;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/wbi2c_ctrl.sv
module wbi2c_ctrl
  import wbi2c_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] wbAdr,
  input  logic [1:0]  wbSel,
  input  logic        wbWe,
  input  logic        wbStb,
  input  logic        wbCyc,
  output logic        wbAck,
  output busStrb_t    strb
);

  logic ackQ;
  logic accept;

  assign accept = wbCyc & wbStb & ~ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= accept;
  end

  assign wbAck = ackQ;

  always_comb begin
    strb.wrEn   = accept & wbWe;
    strb.rdEn   = accept & ~wbWe;
    strb.sel    = decodeAddr(wbAdr);
    strb.byteEn = wbSel;
  end

endmodule

// File: rtl/wbi2c_dp.sv
module wbi2c_dp
  import wbi2c_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrb_t          strb,
  input  logic [BUS_W-1:0]  wbDatI,
  output logic [BUS_W-1:0]  wbDatO,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [7:0]        wrByte,
  output logic              wrLast,
  output logic              wrValid,
  input  logic              wrReady,
  input  logic [7:0]        rdData,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic              engBusy,
  input  logic              engBusCtl,
  input  logic              engBusAct,
  input  logic              engMissAck,
  input  logic              cmdEmpty,
  input  logic              wrEmpty,
  input  logic              rdFull,
  output logic [PRE_W-1:0]  prescale,
  output logic              clkEn,
  output logic              irq,
  output logic [IRQ_N-1:0]  risQ,
  output logic [IRQ_N-1:0]  maskQ,
  output logic [2:0]        stickyQ
);

  localparam int LANES = (PRE_W + 7) / 8;

  logic wrStat, wrPre, wrIm, wrIc, wrGclk;
  logic missAckQ, cmdOvfQ, wrOvfQ;
  logic [PRE_W-1:0] preQ;
  logic clkEnQ;
  logic [IRQ_N-1:0] srcVec, srcPrevQ, misVec;
  logic [BUS_W-1:0] statWord, rdMux;

  assign wrStat = strb.wrEn && strb.sel == SEL_STAT;
  assign wrPre  = strb.wrEn && strb.sel == SEL_PRE;
  assign wrIm   = strb.wrEn && strb.sel == SEL_IM;
  assign wrIc   = strb.wrEn && strb.sel == SEL_IC;
  assign wrGclk = strb.wrEn && strb.sel == SEL_GCLK;

  // engine-facing pushes and pops
  assign cmdValid = strb.wrEn && strb.sel == SEL_CMD;
  assign cmdWord  = wbDatI[CMD_W-1:0];
  assign wrValid  = strb.wrEn && strb.sel == SEL_DATA;
  assign wrByte   = wbDatI[7:0];
  assign wrLast   = wbDatI[9];
  assign rdReady  = strb.rdEn && strb.sel == SEL_DATA && rdValid;

  // sticky error flags: set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missAckQ <= 1'b0;
      cmdOvfQ  <= 1'b0;
      wrOvfQ   <= 1'b0;
    end else begin
      if (engMissAck)                 missAckQ <= 1'b1;
      else if (wrStat && wbDatI[3])   missAckQ <= 1'b0;
      if (cmdValid && !cmdReady)      cmdOvfQ  <= 1'b1;
      else if (wrStat && wbDatI[10])  cmdOvfQ  <= 1'b0;
      if (wrValid && !wrReady)        wrOvfQ   <= 1'b1;
      else if (wrStat && wbDatI[13])  wrOvfQ   <= 1'b0;
    end
  end

  assign stickyQ = {wrOvfQ, cmdOvfQ, missAckQ};

  assign statWord = {rdFull, ~rdValid, wrOvfQ, ~wrReady, wrEmpty,
                     cmdOvfQ, ~cmdReady, cmdEmpty, 4'b0000,
                     missAckQ, engBusAct, engBusCtl, engBusy};

  // interrupt sources, in raw-flag bit order
  assign srcVec = {rdFull, ~rdValid, wrOvfQ, ~wrReady, wrEmpty,
                   cmdOvfQ, ~cmdReady, cmdEmpty, missAckQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcPrevQ <= '0;
    else       srcPrevQ <= srcVec;
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : gRaw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         risQ[i] <= 1'b0;
      else if (srcVec[i] && !srcPrevQ[i]) risQ[i] <= 1'b1;
      else if (wrIc && wbDatI[i])        risQ[i] <= 1'b0;
    end
  end

  // mask register, byte-lane writes
  for (genvar i = 0; i < IRQ_N; i++) begin : gMask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          maskQ[i] <= 1'b0;
      else if (wrIm && strb.byteEn[i/8])  maskQ[i] <= wbDatI[i];
    end
  end

  // prescale register, byte-lane writes
  for (genvar i = 0; i < PRE_W; i++) begin : gPre
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     preQ[i] <= 1'b0;
      else if (wrPre && strb.byteEn[(i/8) % LANES])  preQ[i] <= wbDatI[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        clkEnQ <= 1'b0;
    else if (wrGclk && strb.byteEn[0]) clkEnQ <= wbDatI[0];
  end

  assign prescale = preQ;
  assign clkEn    = clkEnQ;
  assign misVec   = risQ & maskQ;
  assign irq      = |misVec;

  always_comb begin
    case (strb.sel)
      SEL_STAT: rdMux = statWord;
      SEL_DATA: rdMux = rdValid ? {7'b0, 1'b1, rdData} : '0;
      SEL_PRE:  rdMux = BUS_W'(preQ);
      SEL_IM:   rdMux = BUS_W'(maskQ);
      SEL_MIS:  rdMux = BUS_W'(misVec);
      SEL_RIS:  rdMux = BUS_W'(risQ);
      SEL_GCLK: rdMux = BUS_W'(clkEnQ);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wbDatO <= '0;
    else if (strb.rdEn) wbDatO <= rdMux;
  end

endmodule

// File: rtl/wb_i2c_regs.sv
module wb_i2c_regs
  import wbi2c_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       wbAdr,
  input  logic [BUS_W-1:0]  wbDatI,
  output logic [BUS_W-1:0]  wbDatO,
  input  logic [1:0]        wbSel,
  input  logic              wbWe,
  input  logic              wbStb,
  input  logic              wbCyc,
  output logic              wbAck,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [7:0]        wrByte,
  output logic              wrLast,
  output logic              wrValid,
  input  logic              wrReady,
  input  logic [7:0]        rdData,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic              engBusy,
  input  logic              engBusCtl,
  input  logic              engBusAct,
  input  logic              engMissAck,
  input  logic              cmdEmpty,
  input  logic              wrEmpty,
  input  logic              rdFull,
  output logic [PRE_W-1:0]  prescale,
  output logic              clkEn,
  output logic              irq
);

  busStrb_t         strb;
  logic [IRQ_N-1:0] risQ;
  logic [IRQ_N-1:0] maskQ;
  logic [2:0]       stickyQ;

  wbi2c_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wbAdr(wbAdr), .wbSel(wbSel), .wbWe(wbWe),
    .wbStb(wbStb), .wbCyc(wbCyc), .wbAck(wbAck), .strb(strb)
  );

  wbi2c_dp #(.PRE_W(PRE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wbDatI(wbDatI), .wbDatO(wbDatO),
    .cmdWord(cmdWord), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .wrByte(wrByte), .wrLast(wrLast), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .engBusy(engBusy), .engBusCtl(engBusCtl), .engBusAct(engBusAct),
    .engMissAck(engMissAck), .cmdEmpty(cmdEmpty), .wrEmpty(wrEmpty),
    .rdFull(rdFull), .prescale(prescale), .clkEn(clkEn), .irq(irq),
    .risQ(risQ), .maskQ(maskQ), .stickyQ(stickyQ)
  );

endmodule

// File: rtl/wb_i2c_regs_chk.sv
module wb_i2c_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wbCyc,
  input logic       wbStb,
  input logic       wbAck,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic       wrValid,
  input logic       wrReady,
  input logic       rdValid,
  input logic       rdReady,
  input logic       irq,
  input logic [8:0] risQ,
  input logic [8:0] maskQ,
  input logic [2:0] stickyQ
);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |=> !wbAck); // R1
  AST_ACK_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |-> $past(wbCyc && wbStb)); // R1
  AST_CMD_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R4
  AST_CMD_DROP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> stickyQ[1]); // R4
  AST_WR_DROP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> stickyQ[2]); // R5
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |-> rdValid); // R6
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (risQ != 9'd0)); // R9
  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == 9'd0) |-> !irq); // R9

endmodule

bind wb_i2c_regs wb_i2c_regs_chk chk_i (
  .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbAck(wbAck),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .wrValid(wrValid),
  .wrReady(wrReady), .rdValid(rdValid), .rdReady(rdReady), .irq(irq),
  .risQ(risQ), .maskQ(maskQ), .stickyQ(stickyQ)
);

// File: tb/wb_i2c_regs_tb_top.sv
module wb_i2c_regs_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] wbAdr = '0, wbDatI = '0, wbDatO;
  logic [1:0]  wbSel = '0;
  logic wbWe = 0, wbStb = 0, wbCyc = 0, wbAck;
  logic [12:0] cmdWord;
  logic cmdValid, cmdReady = 1;
  logic [7:0] wrByte, rdData = '0;
  logic wrLast, wrValid, wrReady = 1, rdValid = 0, rdReady;
  logic engBusy = 0, engBusCtl = 0, engBusAct = 0, engMissAck = 0;
  logic cmdEmpty = 1, wrEmpty = 1, rdFull = 0;
  logic [15:0] prescale;
  logic clkEn, irq;

  wb_i2c_regs dut_i (.*);

  int checks = 0, errors = 0, pops = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic [12:0] expCmdQ[$];
  logic [8:0]  expWrQ[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: compares bus reads and engine pushes against scoreboard queues
  always @(negedge clk) begin
    if (rstN && wbAck && !wbWe) begin
      if (expQ.size() == 0) chk("R1 unexpected read ack", 1, 0);
      else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, wbDatO, e);
      end
    end
    if (rstN && cmdValid && cmdReady) begin
      if (expCmdQ.size() == 0) chk("R4 unexpected command push", 1, 0);
      else begin
        logic [12:0] c;
        c = expCmdQ.pop_front();
        chk("R4 command word", cmdWord, c);
      end
    end
    if (rstN && wrValid && wrReady) begin
      if (expWrQ.size() == 0) chk("R5 unexpected data push", 1, 0);
      else begin
        logic [8:0] w;
        w = expWrQ.pop_front();
        chk("R5 data byte and last", {wrLast, wrByte}, w);
      end
    end
    if (rstN && rdValid && rdReady) pops++;
  end

  task automatic busCycle(input logic [15:0] adr, input logic [15:0] dat,
                          input logic we, input logic [1:0] sel);
    int lat;
    @(posedge clk); #1;
    wbAdr = adr; wbDatI = dat; wbWe = we; wbSel = sel; wbCyc = 1; wbStb = 1;
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!wbAck && lat < 20);
    chk("R1 ack latency", lat, 1);
    wbCyc = 0; wbStb = 0;
    @(posedge clk); #1;
    chk("R1 ack single cycle", wbAck, 0);
    wbWe = 0;
  endtask

  task automatic wbWrite(input logic [15:0] adr, input logic [15:0] dat, input logic [1:0] sel);
    busCycle(adr, dat, 1'b1, sel);
  endtask

  task automatic wbRead(input logic [15:0] adr, input logic [15:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busCycle(adr, 16'h0, 1'b0, 2'b11);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset prescale", prescale, 0);
    chk("R2 reset clkEn", clkEn, 0);
    chk("R2 reset irq", irq, 0);
    chk("R2 reset ack", wbAck, 0);
    #1 rstN = 1;
    idle(2);

    wbRead(16'h0000, 16'h4900, "R3 status idle");
    wbRead(16'h000C, 16'h0000, "R2 prescale zero");
    wbRead(16'hFF00, 16'h0000, "R2 mask zero");
    wbRead(16'hFF10, 16'h0000, "R2 clock enable zero");
    wbRead(16'h0010, 16'h0000, "R2 unmapped reads zero");
    engBusy = 1; engBusCtl = 1;
    wbRead(16'h0000, 16'h4903, "R3 status busy bits");
    engBusy = 0; engBusCtl = 0; engBusAct = 1;
    wbRead(16'h0000, 16'h4904, "R3 status bus active");
    engBusAct = 0;

    // pushes toward the engine
    expCmdQ.push_back(13'h1523);
    wbWrite(16'h0004, 16'h1523, 2'b11);
    expWrQ.push_back(9'h155);
    wbWrite(16'h0008, 16'h0255, 2'b11);
    expWrQ.push_back(9'h012);
    wbWrite(16'h0008, 16'h0012, 2'b11);

    // overflow on full FIFOs
    cmdEmpty = 0; wrEmpty = 0; cmdReady = 0;
    wbWrite(16'h0004, 16'h0100, 2'b11);
    wbRead(16'h0000, 16'h4600, "R4 command overflow flag");
    wrReady = 0;
    wbWrite(16'h0008, 16'h0077, 2'b11);
    wbRead(16'h0000, 16'h7600, "R5 write overflow flag");
    wbWrite(16'h0000, 16'h0000, 2'b11);
    wbRead(16'h0000, 16'h7600, "R7 zero write keeps sticky");
    wbWrite(16'h0000, 16'h0400, 2'b11);
    wbRead(16'h0000, 16'h7200, "R7 clear command overflow");
    wbWrite(16'h0000, 16'h2000, 2'b11);
    wbRead(16'h0000, 16'h5200, "R7 clear write overflow");
    cmdReady = 1; wrReady = 1;

    // missed ACK pulse
    @(posedge clk); #1 engMissAck = 1;
    @(posedge clk); #1 engMissAck = 0;
    wbRead(16'h0000, 16'h4008, "R7 missed ACK sticky");
    wbWrite(16'h0000, 16'h0008, 2'b11);
    wbRead(16'h0000, 16'h4000, "R7 missed ACK cleared");

    // read FIFO pops
    rdValid = 1; rdData = 8'hA5;
    wbRead(16'h0008, 16'h01A5, "R6 pop valid byte");
    chk("R6 one pop", pops, 1);
    rdValid = 0;
    wbRead(16'h0008, 16'h0000, "R6 empty read");
    chk("R6 empty read no pop", pops, 1);

    // interrupts
    wbWrite(16'hFF0C, 16'h01FF, 2'b11);
    wbRead(16'hFF08, 16'h0000, "R8 raw cleared");
    wrReady = 0;
    idle(2);
    wbRead(16'hFF08, 16'h0020, "R8 write full edge");
    chk("R9 irq low while unmasked", irq, 0);
    wbWrite(16'hFF00, 16'h0020, 2'b11);
    idle(1);
    chk("R9 irq follows mask", irq, 1);
    wbRead(16'hFF04, 16'h0020, "R9 masked status");
    wbWrite(16'hFF04, 16'h0000, 2'b11);
    wbRead(16'hFF04, 16'h0020, "R8 masked write ignored");
    wbWrite(16'hFF08, 16'h0000, 2'b11);
    wbRead(16'hFF08, 16'h0020, "R8 raw write ignored");
    wbWrite(16'hFF0C, 16'h0020, 2'b11);
    idle(1);
    chk("R9 irq after clear", irq, 0);
    wbRead(16'hFF08, 16'h0000, "R8 raw level does not retrigger");
    wrReady = 1;

    // prescale and clock enable
    wbWrite(16'h000C, 16'hBEEF, 2'b11);
    chk("R10 prescale full write", prescale, 16'hBEEF);
    wbWrite(16'h000C, 16'h1234, 2'b01);
    chk("R10 prescale low lane", prescale, 16'hBE34);
    wbRead(16'h000C, 16'hBE34, "R10 prescale readback");
    wbWrite(16'hFF10, 16'h0001, 2'b11);
    chk("R10 clock enable", clkEn, 1);

    idle(2);
    chk("R4 command queue drained", expCmdQ.size(), 0);
    chk("R5 data queue drained", expWrQ.size(), 0);
    chk("R1 read queue drained", expQ.size(), 0);
    finishRun();
  end

endmodule